// File: doc/BRIEF.md
# D-PHY Test-Port Configuration Writer

This block performs one configuration write into a D-PHY through its serial test port. That port has four inputs: a clear line, a strobe clock, an enable line that selects between address and data, and an 8-bit parallel input. A single write is a fixed choreography of eight phases. The port is cleared, then the strobe is raised. The configuration address is presented with the enable high and captured on the strobe's falling edge. The data value is then presented with the enable low and captured on the strobe's next rising edge. The strobe is finally lowered.

The caller pulses `start_i` and either supplies an explicit address and data pair or asks the block to derive the data itself. In derived mode, the address is the PHY's frequency-band register and the data is a band code taken from a 29-entry table of per-lane rate limits. The rate comes from `rate_mbps_i`, or from a built-in default when no rate is supplied. A rate beyond the table raises a one-cycle range error and leaves the port untouched. Each phase lasts a caller-chosen number of system clocks so that the PHY's setup and hold windows can be met at any system clock rate.

Top module: `dphy_test_writer`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `testclr_o`, `testclk_o` and `testen_o` are 0, and `done_o` and `range_err_o` are 0 except for their one-cycle pulses.
- R2: Every write begins with a clear phase in which `testclr_o` is 1 while `testclk_o`, `testen_o` and `testdin_o` are all 0. This is followed by a release phase in which all four are 0, and then a phase in which `testclk_o` alone rises.
- R3: During a write, `testclk_o` falls exactly once while `testen_o` is 1, and at that edge `testdin_o` holds the address. `testdin_o` is stable across the edge.
- R4: After the address edge, `testclk_o` rises exactly once with `testen_o` at 0, and at that edge `testdin_o` holds the data value. Every rising edge of `testclk_o` occurs with `testen_o` at 0.
- R5: Each of the eight phases lasts max(`hold_i`,1) cycles, with `hold_i` sampled at start, so `busy_o` is high for exactly 8×max(`hold_i`,1) consecutive cycles, beginning in the cycle after `start_i` is taken.
- R6: `done_o` is high for exactly one cycle, in the first cycle after `busy_o` falls. A `start_i` pulse while `busy_o` is high is ignored and does not change the write in progress.
- R7: In derived mode (`use_rate_i`=1), the address is 0x44, and the data is the code of the first entry whose limit is strictly greater than the rate. The entries are listed as limit:code in hex, in increasing limit order: 90:00 100:20 110:40 125:02 140:22 150:42 160:04 180:24 200:44 210:06 240:26 250:46 270:08 300:28 330:48 360:2a 400:4a 450:0c 500:2c 550:0e 600:2e 650:10 700:30 750:12 800:32 850:14 900:34 950:54 1000:74.
- R8: In derived mode with `rate_given_i`=0, `rate_mbps_i` is ignored and a rate of 849 is used, which gives data 0x14.
- R9: In derived mode with an effective rate of 1000 or more, `range_err_o` pulses for one cycle in the cycle after the start. In that case `busy_o` stays low, `done_o` stays low, and no test-port pin moves.
- R10: In explicit mode (`use_rate_i`=0), `code_i` and `data_i`, sampled at start, are written unchanged, and `rate_mbps_i` and `rate_given_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a write |
| use_rate_i | input | 1 | 1: derive the write from a lane rate; 0: use code_i/data_i |
| rate_given_i | input | 1 | In derived mode, 1 uses rate_mbps_i, 0 uses the default rate |
| rate_mbps_i | input | RATE_W | Per-lane rate in Mbps |
| code_i | input | 8 | Explicit test address |
| data_i | input | 8 | Explicit test data |
| hold_i | input | HOLD_W | Cycles per phase (0 behaves as 1) |
| testclr_o | output | 1 | Test-port clear |
| testclk_o | output | 1 | Test-port strobe |
| testen_o | output | 1 | Test-port enable: 1 means address, 0 means data |
| testdin_o | output | 8 | Test-port parallel input |
| busy_o | output | 1 | A write is in progress |
| done_o | output | 1 | One-cycle pulse when a write completes |
| range_err_o | output | 1 | One-cycle pulse when the rate is beyond the table |

## Verification
The bench builds the block with its default parameters: an 11-bit rate input and a 4-bit phase hold. The rate width lets the bench reach values well past the last table limit, so the range error can be driven from 1000 up to 2047. The hold width lets it cover zero, one and the maximum of fifteen cycles per phase. Directed writes probe both sides of several table limits and the default-rate path. Random writes mix the two modes, rates and holds, and one write receives a second start while busy.

// File: rtl/dphy_tw_pkg.sv
package dphy_tw_pkg;

    localparam int TW_W        = 8;
    localparam int NUM_RANGES  = 29;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CLR,
        PH_REL,
        PH_CLKHI,
        PH_CODE,
        PH_CODELAT,
        PH_DATA,
        PH_DATALAT,
        PH_END
    } phase_e;

    typedef struct packed {
        logic            clr;
        logic            clk;
        logic            en;
        logic [TW_W-1:0] din;
    } tport_s;

    typedef struct packed {
        logic [TW_W-1:0] code;
        logic [TW_W-1:0] data;
    } wreq_s;

    typedef struct packed {
        logic [15:0]     limit;
        logic [TW_W-1:0] sel;
    } band_s;

    // Band table in increasing limit order; the order sets the priority.
    function automatic band_s band_entry(input int idx);
        band_s e;
        case (idx)
            0:  e = '{16'd90,   8'h00};
            1:  e = '{16'd100,  8'h20};
            2:  e = '{16'd110,  8'h40};
            3:  e = '{16'd125,  8'h02};
            4:  e = '{16'd140,  8'h22};
            5:  e = '{16'd150,  8'h42};
            6:  e = '{16'd160,  8'h04};
            7:  e = '{16'd180,  8'h24};
            8:  e = '{16'd200,  8'h44};
            9:  e = '{16'd210,  8'h06};
            10: e = '{16'd240,  8'h26};
            11: e = '{16'd250,  8'h46};
            12: e = '{16'd270,  8'h08};
            13: e = '{16'd300,  8'h28};
            14: e = '{16'd330,  8'h48};
            15: e = '{16'd360,  8'h2a};
            16: e = '{16'd400,  8'h4a};
            17: e = '{16'd450,  8'h0c};
            18: e = '{16'd500,  8'h2c};
            19: e = '{16'd550,  8'h0e};
            20: e = '{16'd600,  8'h2e};
            21: e = '{16'd650,  8'h10};
            22: e = '{16'd700,  8'h30};
            23: e = '{16'd750,  8'h12};
            24: e = '{16'd800,  8'h32};
            25: e = '{16'd850,  8'h14};
            26: e = '{16'd900,  8'h34};
            27: e = '{16'd950,  8'h54};
            default: e = '{16'd1000, 8'h74};
        endcase
        return e;
    endfunction

    function automatic phase_e next_phase(input phase_e ph);
        case (ph)
            PH_CLR:     return PH_REL;
            PH_REL:     return PH_CLKHI;
            PH_CLKHI:   return PH_CODE;
            PH_CODE:    return PH_CODELAT;
            PH_CODELAT: return PH_DATA;
            PH_DATA:    return PH_DATALAT;
            PH_DATALAT: return PH_END;
            default:    return PH_IDLE;
        endcase
    endfunction

    function automatic tport_s pins_for(input phase_e ph, input wreq_s rq);
        tport_s p;
        p = '0;
        case (ph)
            PH_CLR:     p.clr = 1'b1;
            PH_CLKHI:   p.clk = 1'b1;
            PH_CODE:    begin p.clk = 1'b1; p.en = 1'b1; p.din = rq.code; end
            PH_CODELAT: begin p.en = 1'b1; p.din = rq.code; end
            PH_DATA:    p.din = rq.data;
            PH_DATALAT: begin p.clk = 1'b1; p.din = rq.data; end
            PH_END:     p.din = rq.data;
            default:    p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dphy_tw_band_lookup.sv
module dphy_tw_band_lookup
    import dphy_tw_pkg::*;
#(
    parameter int RATE_W = 11
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic              ok_o,
    output logic [TW_W-1:0]   sel_o
);
    logic [NUM_RANGES-1:0] below;

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
        localparam band_s ENT = band_entry(i);
        assign below[i] = 32'(rate_i) < 32'(ENT.limit);
    end

    always_comb begin
        ok_o  = 1'b0;
        sel_o = '0;
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (below[i]) begin
                ok_o  = 1'b1;
                sel_o = band_entry(i).sel;
            end
        end
    end
endmodule

// File: rtl/dphy_tw_phase_timer.sv
module dphy_tw_phase_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              run_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              last_o
);
    logic [HOLD_W-1:0] lim_q;
    logic [HOLD_W-1:0] cnt_q;

    assign last_o = run_i && (cnt_q == HOLD_W'(lim_q - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= HOLD_W'(1);
            cnt_q <= '0;
        end else if (load_i) begin
            lim_q <= (hold_i == '0) ? HOLD_W'(1) : hold_i;
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= last_o ? '0 : HOLD_W'(cnt_q + 1'b1);
        end
    end
endmodule

// File: rtl/dphy_tw_sequencer.sv
module dphy_tw_sequencer
    import dphy_tw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   req_ok_i,
    input  wreq_s  req_i,
    input  logic   last_i,
    output logic   accept_o,
    output logic   run_o,
    output tport_s pins_o,
    output logic   done_o,
    output logic   err_o
);
    phase_e ph_q, ph_d;
    wreq_s  rq_q;
    tport_s pins_q;
    logic   done_q, done_d;
    logic   err_q, err_d;
    logic   accept;

    always_comb begin
        ph_d   = ph_q;
        done_d = 1'b0;
        err_d  = 1'b0;
        accept = 1'b0;
        if (ph_q == PH_IDLE) begin
            if (start_i) begin
                if (req_ok_i) begin
                    ph_d   = PH_CLR;
                    accept = 1'b1;
                end else begin
                    err_d = 1'b1;
                end
            end
        end else if (last_i) begin
            ph_d   = next_phase(ph_q);
            done_d = (ph_q == PH_END);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            rq_q   <= '0;
            pins_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            pins_q <= pins_for(ph_d, rq_q);
            done_q <= done_d;
            err_q  <= err_d;
            if (accept) rq_q <= req_i;
        end
    end

    assign accept_o = accept;
    assign run_o    = (ph_q != PH_IDLE);
    assign pins_o   = pins_q;
    assign done_o   = done_q;
    assign err_o    = err_q;
endmodule

// File: rtl/dphy_test_writer.sv
module dphy_test_writer
    import dphy_tw_pkg::*;
#(
    parameter int                RATE_W       = 11,
    parameter int                HOLD_W       = 4,
    parameter logic [TW_W-1:0]   BAND_ADDR    = 8'h44,
    parameter int                DEFAULT_MBPS = 849
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              use_rate_i,
    input  logic              rate_given_i,
    input  logic [RATE_W-1:0] rate_mbps_i,
    input  logic [7:0]        code_i,
    input  logic [7:0]        data_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              testclr_o,
    output logic              testclk_o,
    output logic              testen_o,
    output logic [7:0]        testdin_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              range_err_o
);
    localparam logic [RATE_W-1:0] DEF_RATE = RATE_W'(DEFAULT_MBPS);

    logic [RATE_W-1:0] eff_rate;
    logic              band_ok;
    logic [TW_W-1:0]   band_sel;
    wreq_s             req;
    logic              req_ok;
    logic              accept, run, last;
    tport_s            pins;

    assign eff_rate = rate_given_i ? rate_mbps_i : DEF_RATE;

    dphy_tw_band_lookup #(.RATE_W(RATE_W)) u_lookup (
        .rate_i (eff_rate),
        .ok_o   (band_ok),
        .sel_o  (band_sel)
    );

    always_comb begin
        if (use_rate_i) begin
            req.code = BAND_ADDR;
            req.data = band_sel;
            req_ok   = band_ok;
        end else begin
            req.code = code_i;
            req.data = data_i;
            req_ok   = 1'b1;
        end
    end

    dphy_tw_phase_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .run_i  (run),
        .hold_i (hold_i),
        .last_o (last)
    );

    dphy_tw_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .req_ok_i (req_ok),
        .req_i    (req),
        .last_i   (last),
        .accept_o (accept),
        .run_o    (run),
        .pins_o   (pins),
        .done_o   (done_o),
        .err_o    (range_err_o)
    );

    assign testclr_o = pins.clr;
    assign testclk_o = pins.clk;
    assign testen_o  = pins.en;
    assign testdin_o = pins.din;
    assign busy_o    = run;
endmodule

// File: rtl/dphy_test_writer_chk.sv
module dphy_test_writer_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       testclr_o,
    input logic       testclk_o,
    input logic       testen_o,
    input logic [7:0] testdin_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       range_err_o
);
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!testclr_o && !testclk_o && !testen_o));

    a_r2_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        testclr_o |-> (!testclk_o && !testen_o && testdin_o == 8'h00));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        ($fell(testclk_o) && testen_o) |-> $stable(testdin_o));

    a_r4_rise_en_low: assert property (@(posedge clk) disable iff (rst)
        $rose(testclk_o) |-> !testen_o);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r9_err_no_write: assert property (@(posedge clk) disable iff (rst)
        range_err_o |-> (!busy_o && !done_o && $past(start_i)));
endmodule

bind dphy_test_writer dphy_test_writer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .testclr_o   (testclr_o),
    .testclk_o   (testclk_o),
    .testen_o    (testen_o),
    .testdin_o   (testdin_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .range_err_o (range_err_o)
);

// File: tb/dphy_test_writer_bench.sv
module dphy_test_writer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       use_rate_i = 1'b0;
    logic       rate_given_i = 1'b0;
    logic [10:0] rate_mbps_i = '0;
    logic [7:0] code_i = '0;
    logic [7:0] data_i = '0;
    logic [3:0] hold_i = '0;
    logic       testclr_o, testclk_o, testen_o, busy_o, done_o, range_err_o;
    logic [7:0] testdin_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dphy_test_writer u_dphy_test_writer (
        .clk(clk), .rst(rst), .start_i(start_i), .use_rate_i(use_rate_i),
        .rate_given_i(rate_given_i), .rate_mbps_i(rate_mbps_i),
        .code_i(code_i), .data_i(data_i), .hold_i(hold_i),
        .testclr_o(testclr_o), .testclk_o(testclk_o), .testen_o(testen_o),
        .testdin_o(testdin_o), .busy_o(busy_o), .done_o(done_o),
        .range_err_o(range_err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // Expected band code per R7, -1 when the rate is out of range.
    function automatic int exp_band(input int r);
        if (r < 90)   return 'h00;
        if (r < 100)  return 'h20;
        if (r < 110)  return 'h40;
        if (r < 125)  return 'h02;
        if (r < 140)  return 'h22;
        if (r < 150)  return 'h42;
        if (r < 160)  return 'h04;
        if (r < 180)  return 'h24;
        if (r < 200)  return 'h44;
        if (r < 210)  return 'h06;
        if (r < 240)  return 'h26;
        if (r < 250)  return 'h46;
        if (r < 270)  return 'h08;
        if (r < 300)  return 'h28;
        if (r < 330)  return 'h48;
        if (r < 360)  return 'h2a;
        if (r < 400)  return 'h4a;
        if (r < 450)  return 'h0c;
        if (r < 500)  return 'h2c;
        if (r < 550)  return 'h0e;
        if (r < 600)  return 'h2e;
        if (r < 650)  return 'h10;
        if (r < 700)  return 'h30;
        if (r < 750)  return 'h12;
        if (r < 800)  return 'h32;
        if (r < 850)  return 'h14;
        if (r < 900)  return 'h34;
        if (r < 950)  return 'h54;
        if (r < 1000) return 'h74;
        return -1;
    endfunction

    task automatic run_write(input bit ur, input bit rg, input int rate,
                             input int code, input int data, input int hold,
                             input bit poke);
        int  eff, exp_c, exp_d, hold_eff;
        bit  exp_err;
        int  busy_cnt, done_cnt, err_cnt, addr_falls, data_rises, moves;
        int  got_c, got_d;
        bit  prev_clk, clr_seen, clr_bad, code_done;
        eff      = rg ? rate : 849;
        hold_eff = (hold == 0) ? 1 : hold;
        if (ur) begin
            exp_err = (exp_band(eff) < 0);
            exp_c   = 'h44;
            exp_d   = exp_band(eff);
        end else begin
            exp_err = 1'b0;
            exp_c   = code;
            exp_d   = data;
        end
        busy_cnt = 0; done_cnt = 0; err_cnt = 0; addr_falls = 0;
        data_rises = 0; moves = 0; got_c = -1; got_d = -1;
        prev_clk = 1'b0; clr_seen = 1'b0; clr_bad = 1'b0; code_done = 1'b0;

        @(negedge clk);
        use_rate_i = ur; rate_given_i = rg; rate_mbps_i = 11'(rate);
        code_i = 8'(code); data_i = 8'(data); hold_i = 4'(hold);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (poke && k == 3) begin
                start_i = 1'b1; code_i = ~8'(code); data_i = ~8'(data);
                use_rate_i = 1'b0; hold_i = 4'd2;
            end
            if (poke && k == 4) start_i = 1'b0;
            if (busy_o) busy_cnt++;
            if (done_o) done_cnt++;
            if (range_err_o) err_cnt++;
            if (testclr_o || testclk_o || testen_o) moves++;
            if (testclr_o) begin
                clr_seen = 1'b1;
                if (testclk_o || testen_o || testdin_o != 0) clr_bad = 1'b1;
            end
            if (prev_clk && !testclk_o && testen_o) begin
                addr_falls++; got_c = testdin_o; code_done = 1'b1;
            end
            if (!prev_clk && testclk_o && !testen_o && code_done) begin
                data_rises++; got_d = testdin_o;
            end
            prev_clk = testclk_o;
            if (done_o || range_err_o) break;
            @(negedge clk);
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            if (done_o) done_cnt++;
            if (range_err_o) err_cnt++;
            if (busy_o) busy_cnt++;
            if (testclr_o || testclk_o || testen_o) moves++;
        end

        if (exp_err) begin
            chk(err_cnt == 1, "R9", "range error pulses", err_cnt, 1);
            chk(busy_cnt == 0, "R9", "busy cycles on error", busy_cnt, 0);
            chk(done_cnt == 0, "R9", "done on error", done_cnt, 0);
            chk(moves == 0, "R9", "pin activity on error", moves, 0);
        end else begin
            chk(err_cnt == 0, "R7", "unexpected range error", err_cnt, 0);
            chk(clr_seen && !clr_bad, "R2", "quiet clear phase", int'(clr_bad), 0);
            chk(addr_falls == 1, "R3", "address strobe falls", addr_falls, 1);
            chk(got_c == exp_c, ur ? "R7" : "R10", "address", got_c, exp_c);
            chk(data_rises == 1, "R4", "data strobe rises", data_rises, 1);
            chk(got_d == exp_d, ur ? (rg ? "R7" : "R8") : "R10", "data", got_d, exp_d);
            chk(busy_cnt == 8 * hold_eff, poke ? "R6" : "R5", "busy cycles",
                busy_cnt, 8 * hold_eff);
            chk(done_cnt == 1, "R6", "done pulses", done_cnt, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o && !range_err_o, "R1", "status after reset",
            int'({busy_o, done_o, range_err_o}), 0);
        chk(!testclr_o && !testclk_o && !testen_o, "R1", "pins after reset",
            int'({testclr_o, testclk_o, testen_o}), 0);

        // R10 explicit writes, hold 0 / 1 / max; rate inputs ignored
        run_write(1'b0, 1'b1, 1500, 'h5a, 'hc3, 0, 1'b0);
        run_write(1'b0, 1'b0, 0,    'h01, 'hff, 1, 1'b0);
        run_write(1'b0, 1'b1, 2047, 'hff, 'h00, 15, 1'b0);
        // R7 table boundaries
        run_write(1'b1, 1'b1, 89,  0, 0, 2, 1'b0);
        run_write(1'b1, 1'b1, 90,  0, 0, 1, 1'b0);
        run_write(1'b1, 1'b1, 0,   0, 0, 3, 1'b0);
        run_write(1'b1, 1'b1, 850, 0, 0, 1, 1'b0);
        run_write(1'b1, 1'b1, 999, 0, 0, 4, 1'b0);
        // R8 default rate, supplied rate ignored
        run_write(1'b1, 1'b0, 1500, 0, 0, 2, 1'b0);
        // R9 out of range
        run_write(1'b1, 1'b1, 1000, 0, 0, 2, 1'b0);
        run_write(1'b1, 1'b1, 2047, 0, 0, 5, 1'b0);
        // R6 start while busy is ignored
        run_write(1'b0, 1'b0, 0, 'h3c, 'h96, 3, 1'b1);

        for (int i = 0; i < 20; i++) begin
            bit ur, rg;
            ur = 1'($urandom);
            rg = ($urandom % 4) != 0;
            run_write(ur, rg, int'($urandom % 1100), int'($urandom % 256),
                      int'($urandom % 256), int'($urandom % 16), 1'b0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule